// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM with Late Write

This block models a small synchronous static RAM whose data bus needs no idle cycle when traffic switches between reads and writes. The word is 36 bits wide, made of four 9-bit byte lanes. Address, control and the byte-lane write mask are registered on the rising clock edge. Write data follows its address later, so every clock can carry a transfer. In pipelined mode write data comes two edges after the address. In flow-through mode it comes one edge after.

A static input selects the read timing. Pipelined reads pass through an output register and are valid in the second cycle after the address. Flow-through reads are valid in the first cycle. A read that targets a word whose write has not yet reached the array gets the pending bytes merged over the stored word. The caller therefore always sees results in issue order.

Four-beat bursts start with an address load and continue with advance cycles. A static input picks linear or interleaved beat order. Three chip enables select the device. Two inputs act at once and without a clock: an output enable and a sleep input.

Top module: `nbt_sram`

## Requirements
- R1: A load cycle (adv low) with sleep low is accepted only when ce1_n is low, ce2 is high and ce3_n is low. Otherwise the cycle is a deselect: it changes no array word, and dout_oe stays low in the slot where its read data would have appeared.
- R2: In pipelined mode (pipe_mode=1), a read accepted at edge n drives dout_oe high and the word on dout after edge n+1, until edge n+2.
- R3: In flow-through mode (pipe_mode=0), a read accepted at edge n drives dout_oe high and the word on dout after edge n, until edge n+1.
- R4: A write accepted at edge n takes din at edge n+2 in pipelined mode and at edge n+1 in flow-through mode. din has no effect at any other edge.
- R5: bw_n[i] low writes din bits [9i+8:9i] (lane 0 is bits 8:0). Lanes whose bw_n bit is high keep their old contents.
- R6: Reads and writes may alternate on every clock with no idle cycle. A read returns the word as left by all earlier writes in issue order, including writes still pending, merged lane by lane.
- R7: With burst_ilv=0, the k-th advance cycle after a load at address B (k counted modulo 4) accesses B with its two low bits replaced by B[1:0]+k modulo 4. The upper bits are unchanged and the fifth beat wraps to B. An advance repeats the kind of operation of its load (read, write or deselect) and ignores the chip enables and we_n. bw_n is sampled on every beat.
- R8: With burst_ilv=1, the k-th advance accesses B with low bits B[1:0] XOR k.
- R9: oe_n high forces dout_oe low at once, with no clock edge needed.
- R10: While sleep is high, dout_oe is low at once. An edge with sleep high accepts no access and leaves the burst position unchanged. A write already accepted still takes its data.
- R11: After rst_n (synchronous, active low) is released, dout_oe is low. An advance cycle before any load acts as a deselect. Array contents survive reset.
- R12: dout is all zeros whenever dout_oe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the control pipeline |
| pipe_mode | input | 1 | 1 = pipelined, 0 = flow-through (static) |
| burst_ilv | input | 1 | 1 = interleaved, 0 = linear burst order (static) |
| sleep | input | 1 | Power-down, asynchronous output disable |
| oe_n | input | 1 | Asynchronous output enable, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv | input | 1 | 1 = next burst beat, 0 = load new address |
| we_n | input | 1 | 0 = write, 1 = read on a load cycle |
| bw_n | input | 4 | Per-lane write enables, active low |
| addr | input | 6 | Word address |
| din | input | 36 | Late write data |
| dout | output | 36 | Read data, zero when not driven |
| dout_oe | output | 1 | High while dout carries read data |

## Verification
Some rules hold on every cycle, and the bound checker tests these continuously. They are the output masking by oe_n and sleep, zero data whenever the drive is off, a quiet output after reset, and the drive timing of read and deselect slots in each mode. Data content is another matter. It depends on which bytes which earlier writes left behind. This covers late-write capture, lane masking, forwarding from a pending write and burst address order, and only the bench's reference memory can show it. The bench compares against that memory over full-array sweeps, all lane masks, read-write-read runs on one word, bursts in both orders and random mixed traffic, in both timing modes.

// File: rtl/nbt_sram.sv
module nbt_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pipe_mode,
  input  logic                      burst_ilv,
  input  logic                      sleep,
  input  logic                      oe_n,
  input  logic                      ce1_n,
  input  logic                      ce2,
  input  logic                      ce3_n,
  input  logic                      adv,
  input  logic                      we_n,
  input  logic [LANES-1:0]          bw_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   din,
  output logic [LANES*LANE_W-1:0]   dout,
  output logic                      dout_oe
);
  localparam int DW    = LANES * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [1:0] K_NONE = 2'd0, K_RD = 2'd1, K_WR = 2'd2;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [LANES-1:0] en);
    logic [DW-1:0] r;
    r = old_w;
    for (int i = 0; i < LANES; i++)
      if (en[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    return r;
  endfunction

  logic [DW-1:0]     mem [DEPTH];
  logic [1:0]        bkind, cnt;
  logic [ADDR_W-1:0] base;
  logic [1:0]        s1_k, s2_k;
  logic [ADDR_W-1:0] s1_a, s2_a;
  logic [LANES-1:0]  s1_be, s2_be;
  logic [DW-1:0]     oreg;
  logic              ovld;

  wire              sel    = !ce1_n && ce2 && !ce3_n;
  wire [1:0]        cnt_nx = cnt + 2'd1;
  wire [1:0]        lo_nx  = burst_ilv ? (base[1:0] ^ cnt_nx) : (base[1:0] + cnt_nx);
  wire [ADDR_W-1:0] ea     = adv ? {base[ADDR_W-1:2], lo_nx} : addr;
  wire [1:0]        ld_k   = !sel ? K_NONE : (we_n ? K_RD : K_WR);
  wire [1:0]        kind   = sleep ? K_NONE : (adv ? bkind : ld_k);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bkind <= K_NONE;
      cnt   <= '0;
      base  <= '0;
    end else if (!sleep) begin
      if (adv) cnt <= cnt_nx;
      else begin
        base  <= addr;
        cnt   <= '0;
        bkind <= ld_k;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_k <= K_NONE;
      s2_k <= K_NONE;
    end else begin
      s1_k <= kind;
      s2_k <= s1_k;
    end
    s1_a  <= ea;
    s1_be <= ~bw_n;
    s2_a  <= s1_a;
    s2_be <= s1_be;
  end

  wire [1:0]        wr_k  = pipe_mode ? s2_k  : s1_k;
  wire [ADDR_W-1:0] wr_a  = pipe_mode ? s2_a  : s1_a;
  wire [LANES-1:0]  wr_be = pipe_mode ? s2_be : s1_be;

  always_ff @(posedge clk)
    if (rst_n && wr_k == K_WR) mem[wr_a] <= merge(mem[wr_a], din, wr_be);

  wire          fwd   = pipe_mode && s2_k == K_WR && s2_a == s1_a;
  wire [DW-1:0] rdata = fwd ? merge(mem[s1_a], din, s2_be) : mem[s1_a];

  always_ff @(posedge clk) begin
    if (!rst_n) ovld <= 1'b0;
    else        ovld <= (s1_k == K_RD);
    oreg <= rdata;
  end

  wire          vld  = pipe_mode ? ovld : (s1_k == K_RD);
  wire [DW-1:0] odat = pipe_mode ? oreg : rdata;

  assign dout_oe = vld && !oe_n && !sleep;
  assign dout    = dout_oe ? odat : '0;
endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk #(parameter int DW = 36) (
  input logic          clk,
  input logic          rst_n,
  input logic          pipe_mode,
  input logic          sleep,
  input logic          oe_n,
  input logic          ce1_n,
  input logic          ce2,
  input logic          ce3_n,
  input logic          adv,
  input logic          we_n,
  input logic [DW-1:0] dout,
  input logic          dout_oe
);
  wire sel_in = !ce1_n && ce2 && !ce3_n;
  wire ld_rd  = !sleep && !adv && sel_in && we_n;
  wire ld_off = !sleep && !adv && !sel_in;

  p_zero_when_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> dout == '0);
  p_oe_masks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_oe);
  p_sleep_masks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_oe);
  p_quiet_after_reset_r11: assert property (@(posedge clk)
    $rose(rst_n) |-> !dout_oe);
  p_flow_read_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && ld_rd) |=> (dout_oe || oe_n || sleep));
  p_pipe_read_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && ld_rd) |=> ##1 (dout_oe || oe_n || sleep));
  p_flow_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && ld_off) |=> !dout_oe);
  p_pipe_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && ld_off) |=> ##1 !dout_oe);
endmodule

bind nbt_sram nbt_sram_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .sleep(sleep), .oe_n(oe_n),
  .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .adv(adv), .we_n(we_n),
  .dout(dout), .dout_oe(dout_oe)
);

// File: tb/test_nbt_sram.sv
module test_nbt_sram;
  localparam int MAXN = 1024;
  logic clk = 0, rst_n = 0, pipe_mode = 1, burst_ilv = 0, sleep = 0, oe_n = 0;
  logic ce1_n = 1, ce2 = 0, ce3_n = 1, adv = 0, we_n = 1;
  logic [3:0] bw_n = '1;
  logic [5:0] addr = '0;
  logic [35:0] din = '0, dout;
  logic dout_oe;
  int checks = 0, failures = 0;
  bit done = 0;

  nbt_sram i_nbt_sram (.clk, .rst_n, .pipe_mode, .burst_ilv, .sleep, .oe_n, .ce1_n, .ce2,
    .ce3_n, .adv, .we_n, .bw_n, .addr, .din, .dout, .dout_oe);

  always #2 clk = ~clk;

  logic [35:0] ref_mem [64];
  int          q_k [MAXN];
  logic [2:0]  q_ce [MAXN];
  logic        q_adv [MAXN], q_we [MAXN], q_slp [MAXN], q_oen [MAXN];
  logic [3:0]  q_bw [MAXN];
  logic [5:0]  q_ad [MAXN];
  logic [35:0] q_wd [MAXN], q_ex [MAXN];
  string       q_tag [MAXN];
  int n, bk, dsel_rot;
  logic [5:0] bbase;
  logic [1:0] bcnt;
  bit ilv, pm;

  function automatic logic [35:0] rnd36();
    return 36'({$urandom(), $urandom()});
  endfunction

  function automatic logic [35:0] mrg(logic [35:0] o, logic [35:0] w, logic [3:0] en);
    logic [35:0] r = o;
    for (int i = 0; i < 4; i++) if (en[i]) r[i*9 +: 9] = w[i*9 +: 9];
    return r;
  endfunction

  // kr: 0 deselect, 1 read, 2 write
  task automatic push(int kr, bit a, logic [5:0] ad, logic [3:0] bwn, bit slp, bit oen, string tg);
    int k;
    logic [5:0] e;
    logic [1:0] lo;
    e = ad;
    if (a) begin
      lo = ilv ? (bbase[1:0] ^ (bcnt + 2'd1)) : (bbase[1:0] + bcnt + 2'd1);
      e = {bbase[5:2], lo};
    end
    if (slp) k = 0;
    else if (a) begin bcnt = bcnt + 2'd1; k = bk; end
    else begin bbase = ad; bcnt = 0; bk = kr; k = kr; end
    q_k[n] = k; q_adv[n] = a; q_ad[n] = ad; q_bw[n] = bwn; q_slp[n] = slp; q_oen[n] = oen;
    q_tag[n] = tg;
    if (a) begin q_ce[n] = 3'($urandom_range(0, 7)); q_we[n] = 1'($urandom_range(0, 1)); end
    else begin
      q_we[n] = (kr != 2);
      if (kr != 0) q_ce[n] = 3'b010;
      else begin
        q_ce[n] = (dsel_rot == 0) ? 3'b110 : (dsel_rot == 1) ? 3'b000 : 3'b011;
        q_we[n] = 1'($urandom_range(0, 1));
        dsel_rot = (dsel_rot + 1) % 3;
      end
    end
    if (k == 2) begin q_wd[n] = rnd36(); ref_mem[e] = mrg(ref_mem[e], q_wd[n], ~bwn); end
    if (k == 1) q_ex[n] = ref_mem[e];
    n++;
  endtask

  task automatic check(bit ok, string tg, logic [36:0] act, logic [36:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  task automatic execute();
    int wl, rl, r;
    bit oen, slp, on;
    string tg;
    wl = pm ? 2 : 1;
    rl = pm ? 2 : 1;
    for (int c = 0; c < n + 3; c++) begin
      @(negedge clk);
      if (c < n) begin
        {ce1_n, ce2, ce3_n} = q_ce[c]; adv = q_adv[c]; we_n = q_we[c]; bw_n = q_bw[c];
        addr = q_ad[c]; sleep = q_slp[c]; oe_n = q_oen[c];
      end else begin
        {ce1_n, ce2, ce3_n} = 3'b100; adv = 0; we_n = 1; bw_n = '1; sleep = 0; oe_n = 0;
      end
      din = (c - wl >= 0 && c - wl < n && q_k[c - wl] == 2) ? q_wd[c - wl] : rnd36();
      oen = oe_n; slp = sleep;
      #1;
      r = c - rl;
      on = (r >= 0 && r < n && q_k[r] == 1);
      if (on && oen) tg = "R9";
      else if (on && slp) tg = "R10";
      else if (on) tg = q_tag[r];
      else tg = "R12";
      if (on && !oen && !slp)
        check(dout_oe === 1'b1 && dout === q_ex[r], tg, {dout_oe, dout}, {1'b1, q_ex[r]});
      else
        check(dout_oe === 1'b0 && dout === '0, tg, {dout_oe, dout}, 37'd0);
    end
  endtask

  task automatic run_cfg(bit p, bit il, bit first);
    logic [5:0] a, b;
    string rtag, btag;
    pm = p; ilv = il;
    @(negedge clk);
    rst_n = 0; pipe_mode = p; burst_ilv = il;
    {ce1_n, ce2, ce3_n} = 3'b100; adv = 0; sleep = 0; oe_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 check(dout_oe === 1'b0 && dout === '0, "R11", {dout_oe, dout}, 37'd0);
    n = 0; bk = 0; bcnt = 0; bbase = 0; dsel_rot = 0;
    rtag = p ? "R2" : "R3";
    btag = il ? "R8" : "R7";
    push(1, 1, 6'd5, 4'h0, 0, 0, "R11");
    if (!first) for (int i = 0; i < 8; i++) push(1, 0, 6'(i * 7), 4'hF, 0, 0, "R11");
    for (int i = 0; i < 64; i++) push(2, 0, 6'(i), 4'h0, 0, 0, "R4");
    for (int i = 0; i < 64; i++) push(1, 0, 6'(i), 4'hF, 0, 0, rtag);
    for (int i = 0; i < 16; i++) push(2, 0, 6'(i + 32), 4'(i), 0, 0, "R5");
    for (int i = 0; i < 16; i++) push(1, 0, 6'(i + 32), 4'hF, 0, 0, "R5");
    for (int i = 0; i < 8; i++) begin
      a = 6'($urandom_range(0, 63));
      push(1, 0, a, 4'hF, 0, 0, "R6");
      push(2, 0, a, 4'($urandom_range(0, 15)), 0, 0, "R6");
      push(1, 0, a, 4'hF, 0, 0, "R6");
      push(2, 0, a, 4'($urandom_range(0, 15)), 0, 0, "R6");
      push(1, 0, a, 4'hF, 0, 0, "R6");
      push(1, 0, a, 4'hF, 0, 0, "R6");
    end
    for (int j = 0; j < 4; j++) begin
      b = 6'(8 * j + j);
      push(2, 0, b, 4'h0, 0, 0, btag);
      repeat (3) push(0, 1, 6'h3F, 4'h0, 0, 0, btag);
      push(1, 0, b, 4'hF, 0, 0, btag);
      repeat (4) push(0, 1, 6'h00, 4'hF, 0, 0, btag);
      for (int i = 0; i < 4; i++) push(1, 0, {b[5:2], 2'(i)}, 4'hF, 0, 0, btag);
    end
    for (int i = 0; i < 6; i++) begin
      a = 6'($urandom_range(0, 63));
      push(1, 0, a, 4'hF, 0, 0, "R1");
      push(0, 0, a, 4'h0, 0, 0, "R1");
      push(0, 1, a, 4'h0, 0, 0, "R1");
      push(1, 0, a, 4'hF, 0, 0, "R1");
    end
    a = 6'd50; b = 6'd51;
    push(2, 0, a, 4'h0, 0, 0, "R10");
    push(0, 0, a, 4'h0, 1, 0, "R10");
    push(2, 0, b, 4'h0, 1, 0, "R10");
    push(1, 0, a, 4'hF, 1, 0, "R10");
    push(1, 0, a, 4'hF, 0, 0, "R10");
    push(1, 0, b, 4'hF, 0, 0, "R10");
    push(1, 0, 6'd17, 4'hF, 0, 0, "R10");
    push(0, 1, 6'd0, 4'hF, 0, 0, "R10");
    push(0, 1, 6'd0, 4'hF, 1, 0, "R10");
    push(0, 1, 6'd0, 4'hF, 0, 0, "R10");
    push(0, 1, 6'd0, 4'hF, 0, 0, "R10");
    for (int i = 0; i < 12; i++) push(1, 0, 6'(i), 4'hF, 0, 1'(i % 3 == 1), "R9");
    for (int i = 0; i < 250; i++)
      push($urandom_range(0, 2), 1'($urandom_range(0, 3) == 0), 6'($urandom_range(0, 63)),
           4'($urandom_range(0, 15)), 1'($urandom_range(0, 19) == 0),
           1'($urandom_range(0, 9) == 0), "R6");
    execute();
  endtask

  initial begin
    run_cfg(1, 0, 1);
    run_cfg(1, 1, 0);
    run_cfg(0, 0, 0);
    run_cfg(0, 1, 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule